// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the write-enable latch of a serial NOR flash slave and decides whether a state-changing instruction may run. The serial front end decodes each transaction. When chip select returns high, it presents one event to this block. The event carries the opcode, the target address and the number of clock edges counted while chip select was low. The block checks that event against five things: the latch, the block-protect bits, the hardware lock, the transaction length and the busy state of the array engine. It then reports either an accept pulse, which also launches the engine, or a reject pulse with a reason code.

The protected region grows downward from the top of the array. The array size is a build parameter, so one design serves both the 128 KB and the 256 KB organisation. A busy input stands in for the program and erase engine. The latch stays armed through an accepted operation and drops when busy falls at the end of it. A low level on the hold pin freezes the command path, but it does not stop an operation that is already running.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset `wel_o` is 0. A WREN event (opcode 0x06) sets it, and a WRDI event (opcode 0x04) clears it. Both take effect one cycle after the event.
- R2: A modifying command is one of WRSR 0x01, PP 0x02, SE 0xD8 or BE 0xC7. It is refused with code 1 when `wel_o` is 0. Refusals are checked in this priority order: busy (2), then length (3), then latch (1), then hardware lock (5), then area (4).
- R3: A modifying command whose edge count is not a multiple of eight is refused with code 3.
- R4: PP and SE are refused with code 4 when the address falls in the protected region:
  - block-protect 00 protects nothing;
  - block-protect 01 protects the top quarter of the array;
  - block-protect 10 protects the top half;
  - block-protect 11 protects the whole array.
  On the 128 KB build the top quarter starts at 0x18000; on the 256 KB build it starts at 0x30000.
- R5: BE is refused with code 4 unless both block-protect bits are 0.
- R6: WRSR is refused with code 5 when the status lock bit is 1 and `wp_ni` is 0. Block protection never blocks WRSR.
- R7: A modifying command is refused with code 2 in two cases: while `busy_i` is 1, and while an accepted operation has not yet ended with a busy falling edge.
- R8: The block answers each modifying command one cycle after the event, with exactly one of `accept_o` or `reject_o`. `reject_code_o` is 0 on accept. After an accept, `wel_o` stays 1 until `busy_i` falls and is 0 in the cycle after that fall.
- R9: A refused command leaves `wel_o` unchanged.
- R10: While `hold_ni` is 0, events are ignored: there is no result and no latch change. A busy fall during hold still clears the latch.
- R11: Any other opcode produces no result and leaves `wel_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle event at the chip-select rising edge |
| cmd_op_i | input | 8 | Decoded opcode |
| cmd_addr_i | input | ADDR_W | Target byte address |
| cmd_edges_i | input | CNT_W | Clock edges counted during the transaction |
| wp_ni | input | 1 | Write-protect pin, active low |
| hold_ni | input | 1 | Hold pin, active low |
| sr_bp_i | input | 2 | Block-protect bits from the status register |
| sr_lock_i | input | 1 | Status-write lock bit from the status register |
| busy_i | input | 1 | Array engine busy |
| wel_o | output | 1 | Write-enable latch |
| accept_o | output | 1 | Command accepted; launches the engine |
| reject_o | output | 1 | Command refused |
| reject_code_o | output | 3 | Reason for refusal (0 on accept) |

## Verification
The hardest situation to reach is a command that arrives after an accept but before the engine has raised busy. Both the busy input and the latch look ready at that moment, so only the pending-operation tracking refuses it. The bench issues a second command in the cycle right after an accept, with busy still low, and expects code 2. It also drives hold low for the whole of a busy window, to show that the busy fall still clears the latch. A second instance built for the 128 KB array receives the same events, so an address that is protected on one build and free on the other gives different results.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;

  typedef enum logic [2:0] {
    K_NONE, K_WREN, K_WRDI, K_WRSR, K_PP, K_SE, K_BE
  } cmd_kind_e;

  typedef enum logic [2:0] {
    RJ_NONE   = 3'd0,
    RJ_LATCH  = 3'd1,
    RJ_BUSY   = 3'd2,
    RJ_LEN    = 3'd3,
    RJ_AREA   = 3'd4,
    RJ_HWLOCK = 3'd5
  } rej_code_e;
endpackage

// File: rtl/fwp_decode.sv
module fwp_decode
  import flash_wp_pkg::*;
(
  input  logic [7:0] op_i,
  output cmd_kind_e  kind_o,
  output logic       modify_o
);
  always_comb begin
    unique case (op_i)
      OP_WREN: kind_o = K_WREN;
      OP_WRDI: kind_o = K_WRDI;
      OP_WRSR: kind_o = K_WRSR;
      OP_PP:   kind_o = K_PP;
      OP_SE:   kind_o = K_SE;
      OP_BE:   kind_o = K_BE;
      default: kind_o = K_NONE;
    endcase
    modify_o = (kind_o == K_WRSR) || (kind_o == K_PP) ||
               (kind_o == K_SE) || (kind_o == K_BE);
  end
endmodule

// File: rtl/fwp_region.sv
module fwp_region
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  cmd_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bp_i,
  output logic              blocked_o
);
  localparam int TOP = ADDR_W - 1;
  logic in_zone;

  generate
    if (ADDR_W >= 2) begin : g_wide
      always_comb begin
        unique case (bp_i)
          2'b00: in_zone = 1'b0;
          2'b01: in_zone = addr_i[TOP] & addr_i[TOP-1];
          2'b10: in_zone = addr_i[TOP];
          default: in_zone = 1'b1;
        endcase
      end
    end else begin : g_narrow
      assign in_zone = (bp_i != 2'b00);
    end
  endgenerate

  always_comb begin
    unique case (kind_i)
      K_PP, K_SE: blocked_o = in_zone;
      K_BE:       blocked_o = (bp_i != 2'b00);
      default:    blocked_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fwp_judge.sv
module fwp_judge
  import flash_wp_pkg::*;
(
  input  cmd_kind_e  kind_i,
  input  logic       modify_i,
  input  logic       engaged_i,
  input  logic [2:0] edges_lo_i,
  input  logic       wel_i,
  input  logic       lock_i,
  input  logic       wp_ni,
  input  logic       area_i,
  output logic       ok_o,
  output rej_code_e  code_o
);
  always_comb begin
    ok_o   = 1'b0;
    code_o = RJ_NONE;
    if (modify_i) begin
      if (engaged_i)                               code_o = RJ_BUSY;
      else if (edges_lo_i != 3'd0)                 code_o = RJ_LEN;
      else if (!wel_i)                             code_o = RJ_LATCH;
      else if (kind_i == K_WRSR && lock_i && !wp_ni) code_o = RJ_HWLOCK;
      else if (area_i)                             code_o = RJ_AREA;
      else                                         ok_o   = 1'b1;
    end
  end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int ARRAY_LOG2 = 18,
  parameter int CNT_W      = 16,
  localparam int ADDR_W    = ARRAY_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [CNT_W-1:0]  cmd_edges_i,
  input  logic              wp_ni,
  input  logic              hold_ni,
  input  logic [1:0]        sr_bp_i,
  input  logic              sr_lock_i,
  input  logic              busy_i,
  output logic              wel_o,
  output logic              accept_o,
  output logic              reject_o,
  output logic [2:0]        reject_code_o
);
  cmd_kind_e kind;
  rej_code_e code;
  logic modify, area_hit, ok;
  logic wel_q, pend_q, busy_q, acc_q, rej_q;
  logic [2:0] code_q;
  logic fire, op_done;

  fwp_decode u_dec (.op_i(cmd_op_i), .kind_o(kind), .modify_o(modify));

  fwp_region #(.ADDR_W(ADDR_W)) u_reg (
    .kind_i(kind), .addr_i(cmd_addr_i), .bp_i(sr_bp_i), .blocked_o(area_hit)
  );

  fwp_judge u_jdg (
    .kind_i(kind), .modify_i(modify), .engaged_i(busy_i | pend_q),
    .edges_lo_i(cmd_edges_i[2:0]), .wel_i(wel_q), .lock_i(sr_lock_i),
    .wp_ni(wp_ni), .area_i(area_hit), .ok_o(ok), .code_o(code)
  );

  assign fire    = cmd_valid_i & hold_ni;
  // end of accepted operation: busy falling edge while pending
  assign op_done = pend_q & busy_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
      code_q <= 3'd0;
    end else begin
      busy_q <= busy_i;
      acc_q  <= fire & modify & ok;
      rej_q  <= fire & modify & ~ok;
      code_q <= (fire & modify) ? code : RJ_NONE;
      if (op_done) begin
        wel_q  <= 1'b0;
        pend_q <= 1'b0;
      end
      if (fire) begin
        if (kind == K_WREN) wel_q <= 1'b1;
        if (kind == K_WRDI) wel_q <= 1'b0;
        if (modify && ok)   pend_q <= 1'b1;
      end
    end
  end

  assign wel_o         = wel_q;
  assign accept_o      = acc_q;
  assign reject_o      = rej_q;
  assign reject_code_o = code_q;
endmodule

// File: rtl/fwp_chk.sv
module fwp_chk
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [7:0]        cmd_op_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input logic [CNT_W-1:0]  cmd_edges_i,
  input logic              wp_ni,
  input logic              hold_ni,
  input logic [1:0]        sr_bp_i,
  input logic              sr_lock_i,
  input logic              busy_i,
  input logic              wel_o,
  input logic              accept_o,
  input logic              reject_o,
  input logic [2:0]        reject_code_o
);
  AST_WEL_RISE_FROM_WREN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_o) |-> $past(cmd_valid_i && hold_ni && cmd_op_i == OP_WREN)); // R1
  AST_ACCEPT_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(wel_o)); // R2
  AST_ACCEPT_WHOLE_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(cmd_edges_i[2:0]) == 3'd0); // R3
  AST_BULK_NEEDS_NO_BP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(cmd_op_i) == OP_BE) |-> $past(sr_bp_i) == 2'b00); // R5
  AST_HW_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(cmd_op_i) == OP_WRSR) |-> !($past(sr_lock_i) && !$past(wp_ni))); // R6
  AST_ACCEPT_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> !$past(busy_i)); // R7
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && reject_o)); // R8
  AST_CODE_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o == (reject_code_o != 3'd0)); // R8
  AST_HOLD_MUTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!hold_ni) |-> !accept_o && !reject_o); // R10
endmodule

bind flash_wp_ctrl fwp_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .cmd_addr_i(cmd_addr_i), .cmd_edges_i(cmd_edges_i), .wp_ni(wp_ni),
  .hold_ni(hold_ni), .sr_bp_i(sr_bp_i), .sr_lock_i(sr_lock_i), .busy_i(busy_i),
  .wel_o(wel_o), .accept_o(accept_o), .reject_o(reject_o),
  .reject_code_o(reject_code_o)
);

// File: tb/sim_flash_wp_ctrl.sv
module sim_flash_wp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, en1 = 1'b0;
  logic [7:0] op = 8'h00;
  logic [17:0] addr = '0;
  logic [15:0] edges = '0;
  logic wp_n = 1'b1, hold_n = 1'b1, lock = 1'b0, busy = 1'b0;
  logic [1:0] bp = 2'b00;
  logic wel0, acc0, rej0, wel1, acc1, rej1;
  logic [2:0] code0, code1;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  flash_wp_ctrl #(.ARRAY_LOG2(18)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_op_i(op),
    .cmd_addr_i(addr), .cmd_edges_i(edges), .wp_ni(wp_n), .hold_ni(hold_n),
    .sr_bp_i(bp), .sr_lock_i(lock), .busy_i(busy), .wel_o(wel0),
    .accept_o(acc0), .reject_o(rej0), .reject_code_o(code0));

  flash_wp_ctrl #(.ARRAY_LOG2(17)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid & en1), .cmd_op_i(op),
    .cmd_addr_i(addr[16:0]), .cmd_edges_i(edges), .wp_ni(wp_n), .hold_ni(hold_n),
    .sr_bp_i(bp), .sr_lock_i(lock), .busy_i(busy & en1), .wel_o(wel1),
    .accept_o(acc1), .reject_o(rej1), .reject_code_o(code1));

  typedef struct packed {
    logic [7:0]  op;
    logic [17:0] addr;
    logic [7:0]  edges;
    logic [1:0]  bp;
    logic        lock;
    logic        wp_n;
    logic        wren;
    logic        acc;
    logic [2:0]  code;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{8'h02, 18'h00100, 8'd32, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0}, // R8 plain PP
    '{8'h02, 18'h00100, 8'd32, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1}, // R2 no latch
    '{8'h02, 18'h00100, 8'd33, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 3'd3}, // R3 odd length
    '{8'h02, 18'h30000, 8'd32, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4}, // R4 quarter hit
    '{8'h02, 18'h2FFFF, 8'd32, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0}, // R4 quarter edge
    '{8'hD8, 18'h20000, 8'd32, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4}, // R4 half hit
    '{8'hD8, 18'h1FFFF, 8'd32, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0}, // R4 half edge
    '{8'hD8, 18'h00000, 8'd32, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4}, // R4 all
    '{8'hC7, 18'h00000, 8'd8,  2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0}, // R5 BE ok
    '{8'hC7, 18'h00000, 8'd8,  2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4}, // R5 BE blocked
    '{8'h01, 18'h00000, 8'd16, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 3'd5}, // R6 locked
    '{8'h01, 18'h00000, 8'd16, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0}, // R6 pin high
    '{8'h01, 18'h00000, 8'd16, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0}, // R6 bit clear
    '{8'h01, 18'h00000, 8'd16, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0}, // R6 bp ignored
    '{8'hD8, 18'h00000, 8'd31, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3}, // R2 len over latch
    '{8'hC7, 18'h00000, 8'd9,  2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 3'd3}, // R2 len over area
    '{8'h01, 18'h00000, 8'd16, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1}  // R2 latch over lock
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] o, input logic [17:0] a, input logic [15:0] e);
    @(negedge clk);
    valid = 1'b1; op = o; addr = a; edges = e;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic busy_pulse();
    @(negedge clk); busy = 1'b1;
    repeat (3) @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset wel", {7'd0, wel0}, 8'd0);
    check("R8 reset result", {6'd0, acc0, rej0}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 set / clear
    issue(8'h06, '0, 16'd8);
    check("R1 wren", {7'd0, wel0}, 8'd1);
    issue(8'h04, '0, 16'd8);
    check("R1 wrdi", {7'd0, wel0}, 8'd0);

    // R11 unknown opcode
    issue(8'h06, '0, 16'd8);
    issue(8'h03, 18'h00010, 16'd32);
    check("R11 no result", {6'd0, acc0, rej0}, 8'd0);
    check("R11 wel kept", {7'd0, wel0}, 8'd1);

    // R7 busy input high
    busy = 1'b1;
    issue(8'h02, 18'h00010, 16'd32);
    check("R7 busy reject", {5'd0, code0}, 8'd2);
    check("R9 wel kept on busy", {7'd0, wel0}, 8'd1);
    busy = 1'b0;

    // R7 pending before busy rises
    issue(8'h02, 18'h00010, 16'd32);
    check("R8 accept", {7'd0, acc0}, 8'd1);
    issue(8'hD8, 18'h00010, 16'd32);
    check("R7 pending reject", {5'd0, code0}, 8'd2);
    check("R8 wel held", {7'd0, wel0}, 8'd1);
    busy_pulse();
    check("R8 wel cleared at busy fall", {7'd0, wel0}, 8'd0);

    // R10 hold ignores events, busy fall still clears
    hold_n = 1'b0;
    issue(8'h06, '0, 16'd8);
    check("R10 wren ignored", {7'd0, wel0}, 8'd0);
    hold_n = 1'b1;
    issue(8'h06, '0, 16'd8);
    issue(8'h02, 18'h00010, 16'd32);
    hold_n = 1'b0;
    issue(8'hC7, '0, 16'd8);
    check("R10 no result in hold", {6'd0, acc0, rej0}, 8'd0);
    busy_pulse();
    check("R10 busy fall clears in hold", {7'd0, wel0}, 8'd0);
    hold_n = 1'b1;

    // R4 128 KB build vs 256 KB build
    en1 = 1'b1; bp = 2'b01;
    issue(8'h06, '0, 16'd8);
    issue(8'h02, 18'h18000, 16'd32);
    check("R4 128K quarter hit", {5'd0, code1}, 8'd4);
    check("R4 256K same addr free", {7'd0, acc0}, 8'd1);
    busy_pulse();
    bp = 2'b10;
    issue(8'h06, '0, 16'd8);
    issue(8'h02, 18'h0FFFF, 16'd32);
    check("R4 128K half edge", {7'd0, acc1}, 8'd1);
    busy_pulse();
    check("R8 128K wel cleared", {7'd0, wel1}, 8'd0);
    issue(8'h06, '0, 16'd8);
    issue(8'h02, 18'h10000, 16'd32);
    check("R4 128K half hit", {5'd0, code1}, 8'd4);
    busy_pulse();
    issue(8'h04, '0, 16'd8);
    en1 = 1'b0; bp = 2'b00;

    for (int i = 0; i < NV; i++) begin
      bp = VEC[i].bp; lock = VEC[i].lock; wp_n = VEC[i].wp_n;
      if (VEC[i].wren) issue(8'h06, '0, 16'd8);
      issue(VEC[i].op, VEC[i].addr, {8'd0, VEC[i].edges});
      check($sformatf("R2 vec%0d accept", i), {7'd0, acc0}, {7'd0, VEC[i].acc});
      check($sformatf("R2 vec%0d code", i), {5'd0, code0}, {5'd0, VEC[i].code});
      if (VEC[i].acc) begin
        busy_pulse();
        check($sformatf("R8 vec%0d wel after op", i), {7'd0, wel0}, 8'd0);
      end else begin
        check($sformatf("R9 vec%0d wel kept", i), {7'd0, wel0}, {7'd0, VEC[i].wren});
        issue(8'h04, '0, 16'd8);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule